// File: doc/BRIEF.md
# Thread Yield and Deactivation Controller

This block settles a yield request issued by a hardware thread context in a multithreaded core. The request carries the index of the yielding context, the binding group it belongs to, a signed source value and a qualifier mask. The block compares the request against the status records of every configured context. From that comparison it takes one of three outcomes. It can retire the caller by clearing its activated flag. It can raise a thread exception with a subcode that names the cause. Otherwise it completes normally. In every case it hands back the source value ANDed with the mask.

The status records are supplied by the surrounding core as flat vectors: a group number, a dynamic flag, a halted flag and an activated flag for each context. The only write the block makes to those records is the clear-activated strobe. A configuration field gives the index of the last context to examine, so the number of contexts scanned is that field plus one. A yield-scheduling-interrupt enable decides whether negative source values may fault. Each request is accepted by a valid/ready handshake. The block answers one cycle later with a single done pulse and an outcome code.

Top module: `thread_yield_ctrl`

## Requirements
- R1: After reset, done, act_clr_valid and exc_valid are low and req_ready is high.
- R2: Only contexts with index less than or equal to cfg_last_ctx are examined; a context with a higher index never counts as a peer.
- R3: A context counts as a runnable peer only if all of the following hold: its group equals req_group, its index differs from req_ctx, its dynamic flag is 1, its halted flag is 0, and its activated flag is 1.
- R4: A zero source with at least one runnable peer reports done_kind 1 (deactivate) and pulses act_clr_valid with act_clr_ctx equal to req_ctx.
- R5: A zero source with no runnable peer reports done_kind 0 (plain), and act_clr_valid stays low.
- R6: A positive source whose AND with the mask is zero reports done_kind 2 (fault), with exc_valid high and exc_code 2.
- R7: A negative source other than -2 reports done_kind 2, exc_valid and exc_code 4 when ysi_en is 1 and the caller's own dynamic flag is 1.
- R8: A negative source reports done_kind 0 with no exception when it equals -2, when ysi_en is 0, or when the caller's dynamic flag is 0. A positive source with a nonzero masked value also reports done_kind 0.
- R9: result equals req_src AND req_mask on every done pulse. exc_code is 0 whenever exc_valid is low.
- R10: A request is taken on a clock edge where req_valid and req_ready are both high. done is high for exactly the next cycle, and req_ready is low while done is high.
- R11: A fault never clears the caller's activated flag: act_clr_valid is low whenever exc_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Yield request present |
| req_ready | output | 1 | Block can take a request |
| req_ctx | input | CTX_W | Index of the yielding context |
| req_group | input | GRP_W | Binding group of the yielding context |
| req_src | input | DATA_W | Signed source value |
| req_mask | input | DATA_W | Yield qualifier mask |
| cfg_last_ctx | input | CTX_W | Index of the last context to examine |
| ysi_en | input | 1 | Yield-scheduling-interrupt enable |
| ctx_group | input | NUM_CTX*GRP_W | Group number of each context, context i in bits [i*GRP_W +: GRP_W] |
| ctx_dyn | input | NUM_CTX | Dynamic flag of each context |
| ctx_halt | input | NUM_CTX | Halted flag of each context |
| ctx_act | input | NUM_CTX | Activated flag of each context |
| done | output | 1 | One-cycle completion pulse |
| done_kind | output | 2 | Outcome: 0 plain, 1 deactivate, 2 fault |
| result | output | DATA_W | Source value ANDed with the mask |
| act_clr_valid | output | 1 | Strobe that clears the activated flag of act_clr_ctx |
| act_clr_ctx | output | CTX_W | Context whose activated flag is cleared |
| exc_valid | output | 1 | Thread exception raised |
| exc_code | output | 3 | Exception subcode: 2 positive-source fault, 4 negative-source fault |

## Verification
All decisions are taken in the cycle the request is accepted, and the registered outcome appears on the next cycle's done pulse. A wrong peer match or a wrong outcome therefore shows up exactly one cycle after acceptance. It shows as the wrong done_kind, a missing or stray act_clr_valid strobe, or a wrong exc_code. The bench sweeps each disqualifying status flag alone, moves the only runnable peer across the configured context limit, and covers the sign cases together with the reserved value. As a result, each term of the peer condition and each outcome branch has its own visible check. A wrong handshake state shows as a done pulse that lasts two cycles, or as req_ready held high during done.

// File: rtl/yld_pkg.sv
package yld_pkg;
   typedef enum logic [1:0] {
      YK_PLAIN = 2'd0,
      YK_DEACT = 2'd1,
      YK_FAULT = 2'd2
   } yld_kind_e;

   localparam logic [2:0] EXC_NONE = 3'd0;
   localparam logic [2:0] EXC_POS  = 3'd2;
   localparam logic [2:0] EXC_NEG  = 3'd4;
endpackage

// File: rtl/yld_peer_scan.sv
module yld_peer_scan #(
   parameter int NUM_CTX = 8,
   parameter int GRP_W   = 2,
   localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
   input  logic [CTX_W-1:0]         caller_ctx,
   input  logic [GRP_W-1:0]         caller_grp,
   input  logic [CTX_W-1:0]         last_ctx,
   input  logic [NUM_CTX*GRP_W-1:0] grp_vec,
   input  logic [NUM_CTX-1:0]       dyn_vec,
   input  logic [NUM_CTX-1:0]       halt_vec,
   input  logic [NUM_CTX-1:0]       act_vec,
   output logic [NUM_CTX-1:0]       peer_vec,
   output logic                     any_peer
);
   for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
      localparam logic [CTX_W-1:0] IDX = CTX_W'(i);
      logic in_range, same_grp, other;
      assign in_range = (IDX <= last_ctx);
      assign same_grp = (grp_vec[i*GRP_W +: GRP_W] == caller_grp);
      assign other    = (IDX != caller_ctx);
      assign peer_vec[i] = in_range & same_grp & other &
                           dyn_vec[i] & ~halt_vec[i] & act_vec[i];
   end

   assign any_peer = |peer_vec;
endmodule

// File: rtl/yld_decide.sv
module yld_decide
   import yld_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic signed [DATA_W-1:0] src,
   input  logic [DATA_W-1:0]        mask,
   input  logic                     any_peer,
   input  logic                     caller_dyn,
   input  logic                     ysi_en,
   output yld_kind_e                kind,
   output logic [2:0]               code,
   output logic [DATA_W-1:0]        masked
);
   localparam logic [DATA_W-1:0] RSV_VAL = {{(DATA_W-2){1'b1}}, 2'b10};

   logic is_zero, is_neg, is_rsv;

   assign masked  = src & mask;
   assign is_zero = (src == '0);
   assign is_neg  = src[DATA_W-1];
   assign is_rsv  = (src == RSV_VAL);

   always_comb begin
      kind = YK_PLAIN;
      code = EXC_NONE;
      if (is_zero) begin
         if (any_peer) kind = YK_DEACT;
      end else if (!is_neg) begin
         if (masked == '0) begin
            kind = YK_FAULT;
            code = EXC_POS;
         end
      end else if (!is_rsv && ysi_en && caller_dyn) begin
         kind = YK_FAULT;
         code = EXC_NEG;
      end
   end
endmodule

// File: rtl/thread_yield_ctrl.sv
module thread_yield_ctrl
   import yld_pkg::*;
#(
   parameter int NUM_CTX = 8,
   parameter int GRP_W   = 2,
   parameter int DATA_W  = 32,
   localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic [CTX_W-1:0]         req_ctx,
   input  logic [GRP_W-1:0]         req_group,
   input  logic signed [DATA_W-1:0] req_src,
   input  logic [DATA_W-1:0]        req_mask,
   input  logic [CTX_W-1:0]         cfg_last_ctx,
   input  logic                     ysi_en,
   input  logic [NUM_CTX*GRP_W-1:0] ctx_group,
   input  logic [NUM_CTX-1:0]       ctx_dyn,
   input  logic [NUM_CTX-1:0]       ctx_halt,
   input  logic [NUM_CTX-1:0]       ctx_act,
   output logic                     done,
   output logic [1:0]               done_kind,
   output logic [DATA_W-1:0]        result,
   output logic                     act_clr_valid,
   output logic [CTX_W-1:0]         act_clr_ctx,
   output logic                     exc_valid,
   output logic [2:0]               exc_code
);
   if (NUM_CTX < 2) begin : g_bad_ctx
      $error("thread_yield_ctrl: NUM_CTX must be at least 2");
   end
   if (GRP_W < 1) begin : g_bad_grp
      $error("thread_yield_ctrl: GRP_W must be at least 1");
   end
   if (DATA_W < 4) begin : g_bad_data
      $error("thread_yield_ctrl: DATA_W must be at least 4");
   end

   logic [NUM_CTX-1:0] peer_vec;
   logic               any_peer;
   logic               caller_dyn;
   yld_kind_e          dec_kind;
   logic [2:0]         dec_code;
   logic [DATA_W-1:0]  dec_masked;
   logic               accept;

   yld_peer_scan #(.NUM_CTX(NUM_CTX), .GRP_W(GRP_W)) u_scan (
      .caller_ctx (req_ctx),
      .caller_grp (req_group),
      .last_ctx   (cfg_last_ctx),
      .grp_vec    (ctx_group),
      .dyn_vec    (ctx_dyn),
      .halt_vec   (ctx_halt),
      .act_vec    (ctx_act),
      .peer_vec   (peer_vec),
      .any_peer   (any_peer)
   );

   always_comb begin
      caller_dyn = 1'b0;
      for (int i = 0; i < NUM_CTX; i++) begin
         if (CTX_W'(i) == req_ctx) caller_dyn = ctx_dyn[i];
      end
   end

   yld_decide #(.DATA_W(DATA_W)) u_decide (
      .src        (req_src),
      .mask       (req_mask),
      .any_peer   (any_peer),
      .caller_dyn (caller_dyn),
      .ysi_en     (ysi_en),
      .kind       (dec_kind),
      .code       (dec_code),
      .masked     (dec_masked)
   );

   assign req_ready = ~done;
   assign accept    = req_valid & req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done          <= 1'b0;
         done_kind     <= YK_PLAIN;
         result        <= '0;
         act_clr_valid <= 1'b0;
         act_clr_ctx   <= '0;
         exc_valid     <= 1'b0;
         exc_code      <= EXC_NONE;
      end else if (accept) begin
         done          <= 1'b1;
         done_kind     <= dec_kind;
         result        <= dec_masked;
         act_clr_valid <= (dec_kind == YK_DEACT);
         act_clr_ctx   <= req_ctx;
         exc_valid     <= (dec_kind == YK_FAULT);
         exc_code      <= dec_code;
      end else begin
         done          <= 1'b0;
         act_clr_valid <= 1'b0;
         exc_valid     <= 1'b0;
         exc_code      <= EXC_NONE;
      end
   end

   // R10: an accepted request completes on the next cycle
   a_r10_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> done);
   // R10: done is a single-cycle pulse
   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R11: fault and deactivation never coincide
   a_r11_fault_keeps_active: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> !act_clr_valid);
   // R6 / R7: only the two defined subcodes are raised
   a_r6_r7_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> (exc_code == EXC_POS || exc_code == EXC_NEG));
   // R4: a clear strobe names the caller and occurs with done
   a_r4_clear_names_caller: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!act_clr_valid || act_clr_ctx == $past(req_ctx)));
   // R9: returned value is the masked source
   a_r9_result_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (result == $past(req_src & req_mask)));
   // R9: no subcode without an exception
   a_r9_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_valid |-> (exc_code == 3'd0));
endmodule

// File: tb/thread_yield_ctrl_bench.sv
module thread_yield_ctrl_bench;
   localparam int NUM_CTX = 8;
   localparam int GRP_W   = 2;
   localparam int DATA_W  = 32;
   localparam int CTX_W   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic                     req_valid = 1'b0;
   logic                     req_ready;
   logic [CTX_W-1:0]         req_ctx = '0;
   logic [GRP_W-1:0]         req_group = '0;
   logic signed [DATA_W-1:0] req_src = '0;
   logic [DATA_W-1:0]        req_mask = '0;
   logic [CTX_W-1:0]         cfg_last_ctx = 3'd7;
   logic                     ysi_en = 1'b0;
   logic [NUM_CTX*GRP_W-1:0] ctx_group = '0;
   logic [NUM_CTX-1:0]       ctx_dyn = '0;
   logic [NUM_CTX-1:0]       ctx_halt = '0;
   logic [NUM_CTX-1:0]       ctx_act = '0;
   logic                     done;
   logic [1:0]               done_kind;
   logic [DATA_W-1:0]        result;
   logic                     act_clr_valid;
   logic [CTX_W-1:0]         act_clr_ctx;
   logic                     exc_valid;
   logic [2:0]               exc_code;

   thread_yield_ctrl #(.NUM_CTX(NUM_CTX), .GRP_W(GRP_W), .DATA_W(DATA_W)) u_thread_yield_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_ctx(req_ctx), .req_group(req_group), .req_src(req_src), .req_mask(req_mask),
      .cfg_last_ctx(cfg_last_ctx), .ysi_en(ysi_en), .ctx_group(ctx_group),
      .ctx_dyn(ctx_dyn), .ctx_halt(ctx_halt), .ctx_act(ctx_act), .done(done),
      .done_kind(done_kind), .result(result), .act_clr_valid(act_clr_valid),
      .act_clr_ctx(act_clr_ctx), .exc_valid(exc_valid), .exc_code(exc_code)
   );

   typedef struct {
      logic [1:0]        kind;
      logic [DATA_W-1:0] res;
      logic              clr;
      logic [CTX_W-1:0]  clr_ctx;
      logic              exc;
      logic [2:0]        code;
      int                cyc;
      string             tag;
   } item_t;

   item_t sb[$];
   int checks = 0;
   int errors = 0;
   int cycle = 0;
   bit finished = 0;

   always @(posedge clk) cycle <= cycle + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic set_ctx(input int i, input logic [GRP_W-1:0] g, input logic d,
                          input logic h, input logic a);
      ctx_group[i*GRP_W +: GRP_W] = g;
      ctx_dyn[i]  = d;
      ctx_halt[i] = h;
      ctx_act[i]  = a;
   endtask

   // Reference model written from the requirements
   function automatic item_t model(input logic [CTX_W-1:0] c, input logic [GRP_W-1:0] g,
                                   input logic signed [DATA_W-1:0] s,
                                   input logic [DATA_W-1:0] m);
      item_t it;
      bit peer = 0;
      for (int i = 0; i < NUM_CTX; i++) begin
         if (i <= int'(cfg_last_ctx) && ctx_group[i*GRP_W +: GRP_W] == g && i != int'(c)
             && ctx_dyn[i] && !ctx_halt[i] && ctx_act[i]) peer = 1;
      end
      it.kind = 2'd0; it.clr = 0; it.clr_ctx = c; it.exc = 0; it.code = 3'd0;
      it.res = s & m;
      if (s == 0) begin
         if (peer) begin it.kind = 2'd1; it.clr = 1; end
      end else if (s > 0) begin
         if ((s & m) == 0) begin it.kind = 2'd2; it.exc = 1; it.code = 3'd2; end
      end else if (s != -2 && ysi_en && ctx_dyn[c]) begin
         it.kind = 2'd2; it.exc = 1; it.code = 3'd4;
      end
      return it;
   endfunction

   task automatic send(input logic [CTX_W-1:0] c, input logic [GRP_W-1:0] g,
                       input logic signed [DATA_W-1:0] s, input logic [DATA_W-1:0] m,
                       input string tag);
      item_t it;
      @(negedge clk);
      req_ctx = c; req_group = g; req_src = s; req_mask = m; req_valid = 1'b1;
      it = model(c, g, s, m);
      it.cyc = cycle + 1;
      it.tag = tag;
      sb.push_back(it);
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
   endtask

   // Monitor: compare each done pulse against the scoreboard
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (done) begin
            check(req_ready == 1'b0, "R10", "ready during done", req_ready, 0);
            if (sb.size() == 0) begin
               check(0, "R10", "unexpected done", 1, 0);
            end else begin
               item_t e;
               e = sb.pop_front();
               check(cycle == e.cyc, "R10", {e.tag, " latency"}, cycle, e.cyc);
               check(done_kind == e.kind, e.tag, "done_kind", done_kind, e.kind);
               check(result == e.res, "R9", {e.tag, " result"}, result, e.res);
               check(act_clr_valid == e.clr, e.tag, "act_clr_valid", act_clr_valid, e.clr);
               if (e.clr)
                  check(act_clr_ctx == e.clr_ctx, "R4", "act_clr_ctx", act_clr_ctx, e.clr_ctx);
               check(exc_valid == e.exc, e.tag, "exc_valid", exc_valid, e.exc);
               check(exc_code == e.code, e.tag, "exc_code", exc_code, e.code);
            end
         end else if (act_clr_valid || exc_valid) begin
            check(0, "R10", "strobe without done", {act_clr_valid, exc_valid}, 0);
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(0, "WATCHDOG", "timeout", 1, 0);
      finish_run();
   end

   task automatic base_cfg();
      cfg_last_ctx = 3'd7;
      ysi_en = 1'b0;
      for (int i = 0; i < NUM_CTX; i++) set_ctx(i, 2'd0, 1'b0, 1'b0, 1'b0);
      set_ctx(0, 2'd0, 1'b1, 1'b0, 1'b1);  // caller
   endtask

   initial begin
      base_cfg();
      repeat (3) @(negedge clk);
      // R1: reset state
      check(done == 0, "R1", "done", done, 0);
      check(act_clr_valid == 0, "R1", "act_clr_valid", act_clr_valid, 0);
      check(exc_valid == 0, "R1", "exc_valid", exc_valid, 0);
      check(req_ready == 1, "R1", "req_ready", req_ready, 1);
      rst_n = 1'b1;

      // R4: a runnable peer exists
      set_ctx(3, 2'd0, 1'b1, 1'b0, 1'b1);
      send(3'd0, 2'd0, 0, 32'hFFFF, "R4");
      send(3'd0, 2'd0, 0, 32'h0, "R4");
      // R3: each disqualifier alone removes the only peer
      set_ctx(3, 2'd1, 1'b1, 1'b0, 1'b1); send(3'd0, 2'd0, 0, 32'h1, "R3");
      set_ctx(3, 2'd0, 1'b0, 1'b0, 1'b1); send(3'd0, 2'd0, 0, 32'h1, "R3");
      set_ctx(3, 2'd0, 1'b1, 1'b1, 1'b1); send(3'd0, 2'd0, 0, 32'h1, "R3");
      set_ctx(3, 2'd0, 1'b1, 1'b0, 1'b0); send(3'd0, 2'd0, 0, 32'h1, "R3");
      // R5: only the caller qualifies
      set_ctx(3, 2'd0, 1'b0, 1'b0, 1'b0);
      send(3'd0, 2'd0, 0, 32'hFFFF_FFFF, "R5");
      // R3: caller in group 2 finds a peer there
      set_ctx(6, 2'd2, 1'b1, 1'b0, 1'b1);
      set_ctx(4, 2'd2, 1'b1, 1'b0, 1'b1);
      send(3'd4, 2'd2, 0, 32'h0, "R3");
      set_ctx(4, 2'd0, 1'b0, 1'b0, 1'b0);
      set_ctx(6, 2'd0, 1'b0, 1'b0, 1'b0);

      // R2: the only peer is context 5, moved across the limit
      set_ctx(5, 2'd0, 1'b1, 1'b0, 1'b1);
      cfg_last_ctx = 3'd4; send(3'd0, 2'd0, 0, 32'h3, "R2");
      cfg_last_ctx = 3'd5; send(3'd0, 2'd0, 0, 32'h3, "R2");
      cfg_last_ctx = 3'd7;

      // R6 / R11: positive source, peer present, masked value zero
      send(3'd0, 2'd0, 5, 32'h2, "R6");
      send(3'd0, 2'd0, 32'h7FFF_FFF0, 32'h0000_000F, "R11");
      // R8: positive with nonzero masked value
      send(3'd0, 2'd0, 5, 32'h4, "R8");

      // R7: negative source faults with ysi_en and caller dynamic
      ysi_en = 1'b1;
      send(3'd0, 2'd0, -1, 32'h00FF_00FF, "R7");
      send(3'd0, 2'd0, -100, 32'hFFFF_FFFF, "R7");
      // R8: reserved value, disabled enable, caller not dynamic
      send(3'd0, 2'd0, -2, 32'hFFFF_FFFF, "R8");
      ysi_en = 1'b0;
      send(3'd0, 2'd0, -1, 32'hF0F0_F0F0, "R8");
      ysi_en = 1'b1;
      set_ctx(0, 2'd0, 1'b0, 1'b0, 1'b1);
      send(3'd0, 2'd0, -7, 32'h0000_FFFF, "R8");
      set_ctx(0, 2'd0, 1'b1, 1'b0, 1'b1);

      // R10: long run of requests, no pulse may be lost
      for (int k = 0; k < 10; k++) send(3'(k % 8), 2'd0, k - 5, 32'(k * 3 + 1), "R10");

      repeat (3) @(negedge clk);
      check(sb.size() == 0, "R10", "pending results", sb.size(), 0);
      finish_run();
   end
endmodule